// File: doc/BRIEF.md
# Dual-View Distributor Control Register

This block is the top-level control register of an interrupt distributor that runs in two security states. It holds three group enables, a flag that turns off the security split, and two read-only affinity-routing indicators. It drives the three enables to the rest of the distributor. Each access carries a security attribute. Secure and non-secure accesses see different bit subsets of the register and may change different bits. When the security split is off, every access sees and writes the same view.

The register sits at one offset of a wider address decoder. It accepts only 32-bit accesses at that offset. A read returns its data in the same cycle as the access. A write takes effect at the next clock edge. Turning the security split off is one-way: the write that does it also clears the secure group-1 enable and the non-secure routing indicator, and the flag stays set until reset. Writes always complete at once, so the write-pending flag never rises.

Register bits used by this project: bit 0 group-0 enable, bit 1 non-secure group-1 enable, bit 2 secure group-1 enable, bit 4 secure routing, bit 5 non-secure routing, bit 6 security-off flag, bit 7 one-of-N wakeup, bit 31 write pending. All other bits read zero.

Top module: `dist_ctl_reg`

## Requirements
- R1: After reset the full view reads 0x0000_0030 (both routing bits one, all else zero), and all three enable outputs and `sec_off` are low.
- R2: With the security split on, a secure 32-bit write at offset 0 loads bits 0, 1 and 2 from the write data. Write-data bits 3, 4, 5, 7 to 31 have no effect.
- R3: With the security split on, a non-secure read returns only bits 31, 4 and 1 of the full view, and every other bit reads zero.
- R4: With the security split on, a non-secure write changes only bit 1. Bits 0, 2 and 6 keep their values.
- R5: A secure write with bit 6 set, made while the split is on, sets the security-off flag. In the same write it clears bit 2 and bit 5, whatever bit 2 of the write data is.
- R6: Once set, the security-off flag ignores writes of zero from any access. Only reset clears it.
- R7: With the security split off, secure and non-secure accesses alike write only bits 0 and 1, and both read the full view.
- R8: Bit 4 always reads one. Bits 7 and 31 always read zero. Writes to these bits have no effect.
- R9: An access at offset 0 whose size code is not 2 (0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit) raises `acc_err` in the same cycle, returns zero read data and changes nothing.
- R10: An access at any other offset raises no error, returns zero read data and changes nothing.
- R11: Outputs `grp0_en`, `grp1ns_en` and `grp1s_en` follow stored bits 0, 1 and 2 from the clock edge that completes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | Security attribute of the access |
| acc_offset | input | ADDR_W | Byte offset in the distributor space |
| acc_size | input | 2 | Size code: 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the access cycle |
| acc_err | output | 1 | Error response for a bad access size at offset 0 |
| grp0_en | output | 1 | Group-0 enable |
| grp1ns_en | output | 1 | Non-secure group-1 enable |
| grp1s_en | output | 1 | Secure group-1 enable |
| sec_off | output | 1 | Security split turned off |

## Verification
On every cycle, assertions check four things: the security-off flag never falls outside reset, the secure group-1 enable stays low while the split is off, a non-secure write with the split on leaves the group-0 and secure group-1 enables alone, and the error response appears only for wrong-size accesses at offset 0. They also check that bit 4 reads one and bit 31 reads zero in any word read. The bench sweeps every combination of enable bits from both security attributes, once with the split on and once with it off. These sweeps show the two read views and write masks. The bench also shows the same-write clearing when the flag is set, the flag surviving later writes, its return to the reset value after a new reset, and the error and stray-offset cases.

// File: rtl/dist_ctl_reg.sv
module dist_ctl_reg #(
  parameter int ADDR_W = 12,
  parameter int REG_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_secure,
  input  logic [ADDR_W-1:0] acc_offset,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       rd_data,
  output logic              acc_err,
  output logic              grp0_en,
  output logic              grp1ns_en,
  output logic              grp1s_en,
  output logic              sec_off
);
  localparam logic [1:0]        SZ_WORD = 2'd2;
  localparam logic [ADDR_W-1:0] OFS     = ADDR_W'(REG_OFFSET);
  localparam logic [31:0]       NS_VIEW = 32'h8000_0012;

  logic en0_q, en1ns_q, en1s_q, off_q;
  logic hit, word, wr_ok;
  logic [31:0] full_view, wmask;

  assign hit   = acc_valid && (acc_offset == OFS);
  assign word  = (acc_size == SZ_WORD);
  assign wr_ok = hit && word && acc_write;
  assign acc_err = hit && !word;

  // bit 31 write-pending and bit 7 wakeup stay zero; bit 5 drops once split is off
  assign full_view = {1'b0, 24'd0, 1'b0, off_q, !off_q, 1'b1, 1'b0,
                      en1s_q, en1ns_q, en0_q};

  always_comb begin
    if (off_q)           wmask = 32'h0000_0003;
    else if (acc_secure) wmask = 32'h0000_0047;
    else                 wmask = 32'h0000_0002;
  end

  always_comb begin
    rd_data = 32'd0;
    if (hit && word && !acc_write)
      rd_data = (!acc_secure && !off_q) ? (full_view & NS_VIEW) : full_view;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en0_q   <= 1'b0;
      en1ns_q <= 1'b0;
      en1s_q  <= 1'b0;
      off_q   <= 1'b0;
    end else if (wr_ok) begin
      if (wmask[0]) en0_q   <= acc_wdata[0];
      if (wmask[1]) en1ns_q <= acc_wdata[1];
      if (wmask[6] && acc_wdata[6]) begin
        off_q  <= 1'b1;
        en1s_q <= 1'b0;
      end else if (wmask[2]) begin
        en1s_q <= acc_wdata[2];
      end
    end
  end

  assign grp0_en   = en0_q;
  assign grp1ns_en = en1ns_q;
  assign grp1s_en  = en1s_q;
  assign sec_off   = off_q;

  assert_off_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_off |=> sec_off);

  assert_no_s1_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_off |-> !grp1s_en);

  assert_ns_write_scope_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !acc_secure && !sec_off && acc_offset == OFS)
      |=> ($stable(grp0_en) && $stable(grp1s_en) && !sec_off));

  assert_err_only_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (acc_valid && acc_offset == OFS && acc_size != SZ_WORD && rd_data == 32'd0));

  assert_fixed_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_offset == OFS && acc_size == SZ_WORD)
      |-> (rd_data[4] && !rd_data[31] && !rd_data[7]));
endmodule

// File: tb/test_dist_ctl_reg.sv
module test_dist_ctl_reg;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_secure = 0;
  logic [11:0] acc_offset = 0;
  logic [1:0] acc_size = 2;
  logic [31:0] acc_wdata = 0;
  logic [31:0] rd_data;
  logic acc_err, grp0_en, grp1ns_en, grp1s_en, sec_off;
  int checks = 0, errors = 0;
  logic m0, m1, m2, moff;

  always #5 clk = ~clk;

  dist_ctl_reg #(.ADDR_W(12), .REG_OFFSET(0)) i_dist_ctl_reg (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_secure(acc_secure), .acc_offset(acc_offset), .acc_size(acc_size),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .acc_err(acc_err),
    .grp0_en(grp0_en), .grp1ns_en(grp1ns_en), .grp1s_en(grp1s_en), .sec_off(sec_off));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_view(input logic sec);
    logic [31:0] v;
    v = 32'h10 | (32'(moff) << 6) | (32'(!moff) << 5) | (32'(m2) << 2) | (32'(m1) << 1) | 32'(m0);
    if (!sec && !moff) v = v & 32'h8000_0012;
    return v;
  endfunction

  task automatic do_write(input logic sec, input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_secure = sec; acc_offset = 0; acc_size = 2; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    if (moff) begin m0 = wd[0]; m1 = wd[1]; end
    else if (!sec) m1 = wd[1];
    else if (wd[6]) begin m0 = wd[0]; m1 = wd[1]; m2 = 0; moff = 1; end
    else begin m0 = wd[0]; m1 = wd[1]; m2 = wd[2]; end
  endtask

  task automatic read_chk(input string req, input logic sec);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_secure = sec; acc_offset = 0; acc_size = 2;
    #1;
    chk(req, rd_data, exp_view(sec));
    chk(req, {28'd0, sec_off, grp1s_en, grp1ns_en, grp0_en}, {28'd0, moff, m2, m1, m0});
    acc_valid = 0;
  endtask

  task automatic do_reset;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m0 = 0; m1 = 0; m2 = 0; moff = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    read_chk("R1 reset secure", 1);
    read_chk("R1 reset ns R3", 0);
    chk("R1 reset value", exp_view(1), 32'h30);

    // R2 R3 R4 R8 R11: sweep with split on
    for (int sec = 0; sec < 2; sec++) begin
      for (int p = 0; p < 8; p++) begin
        for (int noise = 0; noise < 2; noise++) begin
          logic [31:0] wd;
          wd = 32'(p) | (noise != 0 ? 32'hFFFF_FFB8 : 32'h0);
          do_write(sec[0], wd);
          read_chk(sec != 0 ? "R2 R11 secure write" : "R4 R11 ns write", 1);
          read_chk("R3 R8 ns view", 0);
        end
      end
    end

    // R9 bad sizes at offset 0
    do_write(1, 32'h5);
    for (int sz = 0; sz < 4; sz++) begin
      if (sz == 2) continue;
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        acc_valid = 1; acc_write = w[0]; acc_secure = 1; acc_offset = 0;
        acc_size = 2'(sz); acc_wdata = 32'h0000_0042;
        #1;
        chk("R9 error flag", 32'(acc_err), 32'd1);
        chk("R9 zero data", rd_data, 32'd0);
        @(negedge clk);
        acc_valid = 0;
        read_chk("R9 unchanged", 1);
      end
    end

    // R10 other offsets
    for (int o = 1; o < 64; o += 7) begin
      @(negedge clk);
      acc_valid = 1; acc_write = 1; acc_secure = 1; acc_offset = 12'(o * 4);
      acc_size = 2; acc_wdata = 32'h0000_0042;
      #1;
      chk("R10 no error", 32'(acc_err), 32'd0);
      @(negedge clk);
      acc_write = 0;
      #1;
      chk("R10 zero data", rd_data, 32'd0);
      acc_valid = 0;
    end
    read_chk("R10 unchanged", 1);

    // R5: ns attempt to set flag is ignored, then secure sets it
    do_write(0, 32'h0000_0047);
    read_chk("R4 ns cannot set flag", 1);
    do_write(1, 32'h0000_0047);
    read_chk("R5 flag set and bit2 bit5 clear", 1);
    chk("R5 view value", exp_view(1), 32'h53);

    // R6 R7 sweep with split off
    for (int sec = 0; sec < 2; sec++) begin
      for (int p = 0; p < 8; p++) begin
        do_write(sec[0], 32'(p) | 32'hFFFF_FFB8);
        read_chk("R6 R7 secure view", 1);
        read_chk("R7 ns full view", 0);
      end
    end
    chk("R6 flag held", 32'(sec_off), 32'd1);

    // R6 reset clears flag
    do_reset();
    read_chk("R6 R1 reset clears flag", 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule